// File: doc/BRIEF.md
# Status/Cause Interrupt Unmask Logic

This block is the interrupt-gating slice of a system control coprocessor. It keeps two architectural registers: a Status register that software writes in full, and a Cause register in which two software-interrupt bits are written by software while six hardware-interrupt bits follow external lines. A read port returns either register. Status reads merge the live user-mode, error-level and exception-level flags into their bit positions.

The block produces one hardware interrupt request flag. The flag is only re-evaluated when software writes Status and the write changes the global interrupt-enable bit. When enable rises, the flag is raised if the core is not at exception level, not at error level and not in debug mode, and at least one pending bit is both enabled in the newly written Status and set in Cause. When enable falls, the flag is dropped. Any other activity leaves the flag where it was.

Top module: `cop_irq_unmask`

## Requirements
- R1: After a synchronous reset, irq_req is 0, Status reads as 0 with all mode flags low, and Cause reads as 0 with all hardware lines low.
- R2: A write with wr_sel=0 stores all 32 bits of wr_data into Status. rd_data is registered: it shows the register picked by rd_sel (0 Status, 1 Cause) as it stood just before the clock edge.
- R3: A Status read ORs in bit 4 when um_flag is high, bit 2 when erl_flag is high and bit 1 when exl_flag is high. dbg_flag is never folded in.
- R4: A write with wr_sel=1 stores only wr_data bits 9:8 (software interrupts) into Cause. All other written bits are ignored and read back as 0, apart from the hardware field.
- R5: hw_irq[i] is sampled into Cause bit 10+i on every clock edge.
- R6: A Status write that takes bit 0 (interrupt enable) from 0 to 1 sets irq_req on that edge if exl_flag, erl_flag and dbg_flag are all low and bits 15:8 of the written value AND the current Cause are nonzero.
- R7: An enable-rising Status write with any of exl_flag, erl_flag or dbg_flag high, or with no enabled pending bit, leaves irq_req unchanged.
- R8: A Status write that takes bit 0 from 1 to 0 clears irq_req on that edge.
- R9: Status writes that keep bit 0, Cause writes, hardware line changes and mode flag changes leave irq_req unchanged.
- R10: The pending test uses the mask bits carried by the Status value being written, not the Status value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 Status, 1 Cause |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read source: 0 Status, 1 Cause |
| rd_data | output | 32 | Registered read data |
| hw_irq | input | 6 | External interrupt lines into Cause 15:10 |
| exl_flag | input | 1 | Core at exception level |
| erl_flag | input | 1 | Core at error level |
| dbg_flag | input | 1 | Core in debug mode |
| um_flag | input | 1 | Core in user mode |
| irq_req | output | 1 | Hardware interrupt request flag |

## Verification
A Status write changes irq_req on the clock edge that captures the write, so its expected value is due one edge later. A read returns the registers as they stood at the capturing edge, so a value written at one edge appears on rd_data one edge later. A hardware line change needs one edge to reach Cause and another to reach rd_data. Each expected item the driver queues carries the cycle number at which it falls due. The monitor compares items only on the falling edge of that cycle, and so keeps clear of the register updates.

// File: rtl/cop_irq_pkg.sv
package cop_irq_pkg;
  localparam int IE_BIT   = 0;
  localparam int EXL_BIT  = 1;
  localparam int ERL_BIT  = 2;
  localparam int UM_BIT   = 4;
  localparam int PEND_LO  = 8;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_CAUSE  = 1'b1
  } cop_sel_e;
endpackage

// File: rtl/cop_status_reg.sv
module cop_status_reg
  import cop_irq_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stat,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] status_q,
  output logic          ie_rise,
  output logic          ie_fall
);
  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else if (wr_stat) status_q <= wr_data;
  end

  always_comb begin
    ie_rise = wr_stat && !status_q[IE_BIT] &&  wr_data[IE_BIT];
    ie_fall = wr_stat &&  status_q[IE_BIT] && !wr_data[IE_BIT];
  end
endmodule

// File: rtl/cop_cause_reg.sv
module cop_cause_reg
  import cop_irq_pkg::*;
#(
  parameter int DW      = 32,
  parameter int SW_IRQS = 2,
  parameter int HW_IRQS = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_cause,
  input  logic [SW_IRQS-1:0] sw_wdata,
  input  logic [HW_IRQS-1:0] hw_irq,
  output logic [DW-1:0]      cause_q
);
  logic [SW_IRQS-1:0] sw_q;
  logic [HW_IRQS-1:0] hw_q;

  always_ff @(posedge clk) begin
    if (rst) sw_q <= '0;
    else if (wr_cause) sw_q <= sw_wdata;
  end

  for (genvar i = 0; i < HW_IRQS; i++) begin : g_hw
    always_ff @(posedge clk) begin
      if (rst) hw_q[i] <= 1'b0;
      else     hw_q[i] <= hw_irq[i];
    end
  end

  always_comb begin
    cause_q = '0;
    cause_q[PEND_LO +: SW_IRQS]           = sw_q;
    cause_q[PEND_LO + SW_IRQS +: HW_IRQS] = hw_q;
  end
endmodule

// File: rtl/cop_irq_eval.sv
module cop_irq_eval #(
  parameter int PEND_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ie_rise,
  input  logic              ie_fall,
  input  logic              exl_flag,
  input  logic              erl_flag,
  input  logic              dbg_flag,
  input  logic [PEND_W-1:0] new_mask,
  input  logic [PEND_W-1:0] pend,
  output logic              irq_req
);
  logic level_ok;
  logic any_pend;

  always_comb begin
    level_ok = !exl_flag && !erl_flag && !dbg_flag;
    any_pend = |(new_mask & pend);
  end

  always_ff @(posedge clk) begin
    if (rst)                              irq_req <= 1'b0;
    else if (ie_rise && level_ok && any_pend) irq_req <= 1'b1;
    else if (ie_fall)                     irq_req <= 1'b0;
  end
endmodule

// File: rtl/cop_read_mux.sv
module cop_read_mux
  import cop_irq_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_sel,
  input  logic [DW-1:0] status_q,
  input  logic [DW-1:0] cause_q,
  input  logic          exl_flag,
  input  logic          erl_flag,
  input  logic          um_flag,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] fold;

  always_comb begin
    fold          = '0;
    fold[UM_BIT]  = um_flag;
    fold[ERL_BIT] = erl_flag;
    fold[EXL_BIT] = exl_flag;
  end

  always_ff @(posedge clk) begin
    if (rst)                          rd_data <= '0;
    else if (rd_sel == SEL_CAUSE)     rd_data <= cause_q;
    else                              rd_data <= status_q | fold;
  end
endmodule

// File: rtl/cop_irq_unmask.sv
module cop_irq_unmask
  import cop_irq_pkg::*;
#(
  parameter int DW      = 32,
  parameter int SW_IRQS = 2,
  parameter int HW_IRQS = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [DW-1:0]      wr_data,
  input  logic               rd_sel,
  output logic [DW-1:0]      rd_data,
  input  logic [HW_IRQS-1:0] hw_irq,
  input  logic               exl_flag,
  input  logic               erl_flag,
  input  logic               dbg_flag,
  input  logic               um_flag,
  output logic               irq_req
);
  localparam int PEND_W = SW_IRQS + HW_IRQS;

  logic          wr_stat;
  logic          wr_cause;
  logic [DW-1:0] status_q;
  logic [DW-1:0] cause_q;
  logic          ie_rise;
  logic          ie_fall;

  always_comb begin
    wr_stat  = wr_en && (wr_sel == SEL_STATUS);
    wr_cause = wr_en && (wr_sel == SEL_CAUSE);
  end

  cop_status_reg #(.DW(DW)) u_status (
    .clk      (clk),
    .rst      (rst),
    .wr_stat  (wr_stat),
    .wr_data  (wr_data),
    .status_q (status_q),
    .ie_rise  (ie_rise),
    .ie_fall  (ie_fall)
  );

  cop_cause_reg #(.DW(DW), .SW_IRQS(SW_IRQS), .HW_IRQS(HW_IRQS)) u_cause (
    .clk      (clk),
    .rst      (rst),
    .wr_cause (wr_cause),
    .sw_wdata (wr_data[PEND_LO +: SW_IRQS]),
    .hw_irq   (hw_irq),
    .cause_q  (cause_q)
  );

  cop_irq_eval #(.PEND_W(PEND_W)) u_eval (
    .clk      (clk),
    .rst      (rst),
    .ie_rise  (ie_rise),
    .ie_fall  (ie_fall),
    .exl_flag (exl_flag),
    .erl_flag (erl_flag),
    .dbg_flag (dbg_flag),
    .new_mask (wr_data[PEND_LO +: PEND_W]),
    .pend     (cause_q[PEND_LO +: PEND_W]),
    .irq_req  (irq_req)
  );

  cop_read_mux #(.DW(DW)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_sel   (rd_sel),
    .status_q (status_q),
    .cause_q  (cause_q),
    .exl_flag (exl_flag),
    .erl_flag (erl_flag),
    .um_flag  (um_flag),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/cop_irq_unmask_chk.sv
module cop_irq_unmask_chk #(
  parameter int SW_IRQS = 2,
  parameter int HW_IRQS = 6
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       wr_en,
  input logic                       wr_sel,
  input logic                       wr_ie,
  input logic [SW_IRQS+HW_IRQS-1:0] wr_pend,
  input logic                       status_ie_q,
  input logic [SW_IRQS+HW_IRQS-1:0] cause_pend,
  input logic                       rd_sel,
  input logic                       rd_um,
  input logic                       rd_erl,
  input logic                       rd_exl,
  input logic [HW_IRQS-1:0]         hw_irq,
  input logic                       exl_flag,
  input logic                       erl_flag,
  input logic                       dbg_flag,
  input logic                       um_flag,
  input logic                       irq_req
);
  logic st_wr;
  logic rise;
  logic fall;
  logic blocked;
  always_comb begin
    st_wr   = wr_en && !wr_sel;
    rise    = st_wr && !status_ie_q && wr_ie;
    fall    = st_wr && status_ie_q && !wr_ie;
    blocked = exl_flag || erl_flag || dbg_flag || !(|(wr_pend & cause_pend));
  end

  p_fold_r3: assert property (@(posedge clk) disable iff (rst)
    (!rd_sel && um_flag && erl_flag && exl_flag) |=> (rd_um && rd_erl && rd_exl));

  p_hw_track_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cause_pend[SW_IRQS +: HW_IRQS] == $past(hw_irq)));

  p_rise_sets_r6: assert property (@(posedge clk) disable iff (rst)
    (rise && !blocked) |=> irq_req);

  p_rise_blocked_r7: assert property (@(posedge clk) disable iff (rst)
    (rise && blocked) |=> $stable(irq_req));

  p_fall_clears_r8: assert property (@(posedge clk) disable iff (rst)
    fall |=> !irq_req);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!rise && !fall) |=> $stable(irq_req));
endmodule

bind cop_irq_unmask cop_irq_unmask_chk #(.SW_IRQS(SW_IRQS), .HW_IRQS(HW_IRQS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .wr_ie       (wr_data[cop_irq_pkg::IE_BIT]),
  .wr_pend     (wr_data[cop_irq_pkg::PEND_LO +: SW_IRQS+HW_IRQS]),
  .status_ie_q (status_q[cop_irq_pkg::IE_BIT]),
  .cause_pend  (cause_q[cop_irq_pkg::PEND_LO +: SW_IRQS+HW_IRQS]),
  .rd_sel      (rd_sel),
  .rd_um       (rd_data[cop_irq_pkg::UM_BIT]),
  .rd_erl      (rd_data[cop_irq_pkg::ERL_BIT]),
  .rd_exl      (rd_data[cop_irq_pkg::EXL_BIT]),
  .hw_irq      (hw_irq),
  .exl_flag    (exl_flag),
  .erl_flag    (erl_flag),
  .dbg_flag    (dbg_flag),
  .um_flag     (um_flag),
  .irq_req     (irq_req)
);

// File: tb/cop_irq_unmask_bench.sv
module cop_irq_unmask_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic [5:0]  hw_irq = '0;
  logic        exl_flag = 1'b0;
  logic        erl_flag = 1'b0;
  logic        dbg_flag = 1'b0;
  logic        um_flag = 1'b0;
  logic        irq_req;

  always #4 clk = ~clk;

  cop_irq_unmask u_cop_irq_unmask (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .hw_irq(hw_irq), .exl_flag(exl_flag),
    .erl_flag(erl_flag), .dbg_flag(dbg_flag), .um_flag(um_flag), .irq_req(irq_req)
  );

  typedef struct {
    int          due;
    bit          chk_rd;
    logic [31:0] rd;
    logic        irq;
    string       tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_status = '0;
  logic [1:0]  m_sw = '0;
  logic [5:0]  m_hw = '0;
  logic        m_irq = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (irq_req !== e.irq) begin
        n_fail++;
        $display("FAIL %s irq_req actual=%0b expected=%0b", e.tag, irq_req, e.irq);
      end
      if (e.chk_rd) begin
        n_chk++;
        if (rd_data !== e.rd) begin
          n_fail++;
          $display("FAIL %s rd_data actual=%08h expected=%08h", e.tag, rd_data, e.rd);
        end
      end
    end
  end

  function automatic logic [31:0] m_cause();
    return {16'h0, m_hw, m_sw, 8'h00};
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic push(bit chk, logic [31:0] rd, string tag);
    exp_t e;
    e.due = cyc + 1; e.chk_rd = chk; e.rd = rd; e.irq = m_irq; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wr_status(logic [31:0] d, string tag);
    logic rise, fall;
    rise = !m_status[0] && d[0];
    fall = m_status[0] && !d[0];
    if (rise && !exl_flag && !erl_flag && !dbg_flag && ((d & m_cause() & 32'h0000FF00) != 0))
      m_irq = 1'b1;
    else if (fall)
      m_irq = 1'b0;
    m_status = d;
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = d;
    push(1'b0, '0, tag);
    step();
    wr_en = 1'b0;
  endtask

  task automatic wr_cause(logic [31:0] d, string tag);
    m_sw = d[9:8];
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = d;
    push(1'b0, '0, tag);
    step();
    wr_en = 1'b0;
  endtask

  task automatic set_hw(logic [5:0] v);
    hw_irq = v; m_hw = v;
    step();
  endtask

  task automatic rd_status(string tag);
    rd_sel = 1'b0;
    push(1'b1, m_status | {27'h0, um_flag, 1'b0, erl_flag, exl_flag, 1'b0}, tag);
    step();
  endtask

  task automatic rd_cause(string tag);
    rd_sel = 1'b1;
    push(1'b1, m_cause(), tag);
    step();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(); step(); step();
    rst = 1'b0;
    rd_status("R1 reset status");
    rd_cause("R1 reset cause");

    wr_status(32'hA5A5_0000, "R2 write");
    rd_status("R2 readback");
    um_flag = 1'b1; step(); rd_status("R3 um fold");
    um_flag = 1'b0; erl_flag = 1'b1; step(); rd_status("R3 erl fold");
    erl_flag = 1'b0; exl_flag = 1'b1; step(); rd_status("R3 exl fold");
    exl_flag = 1'b0; dbg_flag = 1'b1; step(); rd_status("R3 dbg not folded");
    dbg_flag = 1'b0; step();

    wr_cause(32'hFFFF_FFFF, "R4 cause write");
    rd_cause("R4 only sw bits kept");
    set_hw(6'b101010);
    rd_cause("R5 hw lines");
    wr_cause(32'h0000_0100, "R4 sw bit8");
    set_hw(6'b000000);
    rd_cause("R5 hw cleared");

    wr_status(32'h0000_0101, "R6 rise sets");
    wr_status(32'h0000_0100, "R8 fall clears");
    exl_flag = 1'b1; step();
    wr_status(32'h0000_0101, "R7 exl blocks");
    wr_status(32'h0000_0100, "R8 fall");
    exl_flag = 1'b0; erl_flag = 1'b1; step();
    wr_status(32'h0000_0101, "R7 erl blocks");
    wr_status(32'h0000_0100, "R8 fall");
    erl_flag = 1'b0; dbg_flag = 1'b1; step();
    wr_status(32'h0000_0101, "R7 dbg blocks");
    wr_status(32'h0000_0100, "R8 fall");
    dbg_flag = 1'b0; step();

    wr_cause(32'h0000_0000, "R9 cause clear");
    wr_status(32'h0000_FF01, "R7 nothing pending");
    wr_cause(32'h0000_0200, "R9 cause write keeps flag");
    wr_status(32'h0000_FF01, "R9 same ie keeps flag");
    wr_status(32'h0000_FF00, "R8 fall");
    wr_status(32'h0000_FF01, "R6 rise via sw bit9");
    set_hw(6'b111111);
    push(1'b0, '0, "R9 hw change keeps flag"); step();
    wr_cause(32'h0000_0000, "R9 cause clear keeps flag");
    exl_flag = 1'b1; step();
    push(1'b0, '0, "R9 flag change keeps flag"); step();
    exl_flag = 1'b0; step();
    wr_status(32'h1234_FF01, "R9 rewrite keeps flag");
    wr_status(32'h0000_0000, "R8 fall");
    set_hw(6'b000001);

    wr_status(32'h0000_0801, "R10 mask misses pending");
    wr_status(32'h0000_0000, "R8 fall");
    wr_status(32'h0000_0401, "R10 new mask hits pending");
    rd_status("R2 readback ie set");

    step(); step(); step();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule